// File: doc/BRIEF.md
# Dual-Channel Lock-Step Mode Controller

This block sits behind two self-checking processing channels. Each channel is a pair of cores running in lock-step with its own comparator, so a channel gives a result word, a valid strobe and a compare-error flag each cycle. The controller decides which results may leave the block and on which output port.

In lock-step mode both channels run the same program. Channel 0 is the primary. While it is healthy its result is forwarded on port 0. When it reports a compare error, the result of channel 1 from that same cycle is forwarded instead, so one faulty core is masked. If both channels are lost, every output is silenced and a fatal flag is raised. When both channels are healthy but give different results, a cross-channel error is raised. In parallel mode the channels are two independent fail-silent units, each with its own output port. A mode change takes effect only while the scheduler reports a gap between tasks. A mode change discards any output not yet delivered.

Top module: `lsc_top`

## Requirements
- R1: After reset the controller is in lock-step mode (`lockstep_o`=1), both `out_vld` bits are 0, and `ch_failed`, `fatal_o` and `xchk_err` are 0.
- R2: In lock-step mode with both channels healthy and in agreement, port 0 (`out_dat` bits [DW-1:0]) presents the result of channel 0 (`ch_dat` bits [DW-1:0], valid `ch_vld[0]`) one clock after it is presented.
- R3: In lock-step mode, `out_vld[1]` is always 0.
- R4: In lock-step mode, a compare error on channel 0 makes port 0 carry the result of channel 1 from that same input cycle. Channel 0 is then marked in `ch_failed[0]` until reset, and later results follow channel 1 with no cross-channel check.
- R5: In lock-step mode, when neither channel is usable, `fatal_o` rises and stays set until reset. While it is set, both `out_vld` bits stay 0.
- R6: In lock-step mode with both channels healthy, a difference in valid strobes or in valid data raises `xchk_err` for exactly one cycle, aligned with the output. No result is committed for that cycle.
- R7: A mode write (`mode_wr`=1, `mode_sel` 1 = lock-step, 0 = parallel) is ignored while `sched_idle` is 0.
- R8: An accepted mode write updates `lockstep_o` and clears both `out_vld` bits in the same cycle, even if channels presented valid results.
- R9: In parallel mode, port i forwards channel i one clock later, and each port is independent of the other channel.
- R10: In parallel mode, a compare error on a channel silences only that channel's port, from the same input cycle until reset. It does not raise `fatal_o`.
- R11: A result presented together with its own channel's compare error is never committed on any port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | Requested mode: 1 lock-step, 0 parallel |
| mode_wr | input | 1 | Mode write strobe |
| sched_idle | input | 1 | High between tasks; gates mode writes |
| ch_vld | input | 2 | Result valid per channel |
| ch_dat | input | 2*DW | Result data, channel i in bits [i*DW +: DW] |
| ch_err | input | 2 | Compare error per channel |
| out_vld | output | 2 | Committed result valid per port |
| out_dat | output | 2*DW | Committed data, port i in bits [i*DW +: DW], zero when invalid |
| lockstep_o | output | 1 | Current mode, 1 = lock-step |
| ch_failed | output | 2 | Sticky per-channel failed flags |
| fatal_o | output | 1 | Sticky: both channels lost in lock-step |
| xchk_err | output | 1 | One-cycle cross-channel discrepancy |

## Verification
The bench builds the block with DW=4. With that width it can sweep every data value through the lock-step path. It can also sweep every ordered pair of differing words through the discrepancy check, and the full 16x16 cross product of channel data, with varied valid strobes, through parallel mode. The small width leaves room for the stateful scenarios as well: failover and then loss of both channels, mode writes refused and accepted, and a return to lock-step with one channel already failed.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    localparam int NCH = 2;

    typedef enum logic {
        MODE_PAR  = 1'b0,
        MODE_LOCK = 1'b1
    } mode_e;
endpackage

// File: rtl/lsc_chan_health.sv
// Per-channel usability: a channel is usable this cycle when it has
// not failed before and does not flag a compare error now.
module lsc_chan_health (
    input  logic failed_q,
    input  logic err_i,
    output logic usable_o,
    output logic failed_d
);
    always_comb begin
        usable_o = !failed_q && !err_i;
        failed_d = failed_q || err_i;
    end
endmodule

// File: rtl/lsc_lock_sel.sv
// Lock-step source selection and cross-channel comparison.
module lsc_lock_sel #(
    parameter int DW = 8
) (
    input  logic [1:0]    vld_i,
    input  logic [DW-1:0] dat0_i,
    input  logic [DW-1:0] dat1_i,
    input  logic [1:0]    usable_i,
    output logic          sel_vld_o,
    output logic [DW-1:0] sel_dat_o,
    output logic          mismatch_o,
    output logic          none_o
);
    always_comb begin
        sel_vld_o  = 1'b0;
        sel_dat_o  = '0;
        mismatch_o = 1'b0;
        none_o     = 1'b0;
        if (usable_i[0]) begin
            sel_vld_o = vld_i[0];
            sel_dat_o = dat0_i;
        end else if (usable_i[1]) begin
            sel_vld_o = vld_i[1];
            sel_dat_o = dat1_i;
        end else begin
            none_o = 1'b1;
        end
        if (usable_i[0] && usable_i[1]) begin
            mismatch_o = (vld_i[0] != vld_i[1]) ||
                         (vld_i[0] && (dat0_i != dat1_i));
        end
    end
endmodule

// File: rtl/lsc_top.sv
module lsc_top
    import lsc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              mode_wr,
    input  logic              sched_idle,
    input  logic [1:0]        ch_vld,
    input  logic [2*DW-1:0]   ch_dat,
    input  logic [1:0]        ch_err,
    output logic [1:0]        out_vld,
    output logic [2*DW-1:0]   out_dat,
    output logic              lockstep_o,
    output logic [1:0]        ch_failed,
    output logic              fatal_o,
    output logic              xchk_err
);
    localparam int TOTW = NCH * DW;

    typedef struct packed {
        mode_e           mode;
        logic [NCH-1:0]  failed;
        logic            fatal;
        logic            xerr;
        logic [NCH-1:0]  ovld;
        logic [TOTW-1:0] odat;
    } state_t;

    state_t s_d, s_q;

    logic [NCH-1:0] usable;
    logic [NCH-1:0] failed_nx;
    logic           sel_vld;
    logic [DW-1:0]  sel_dat;
    logic           mismatch;
    logic           none_ok;

    for (genvar i = 0; i < NCH; i++) begin : g_health
        lsc_chan_health u_health (
            .failed_q (s_q.failed[i]),
            .err_i    (ch_err[i]),
            .usable_o (usable[i]),
            .failed_d (failed_nx[i])
        );
    end

    lsc_lock_sel #(.DW(DW)) u_sel (
        .vld_i      (ch_vld),
        .dat0_i     (ch_dat[DW-1:0]),
        .dat1_i     (ch_dat[2*DW-1:DW]),
        .usable_i   (usable),
        .sel_vld_o  (sel_vld),
        .sel_dat_o  (sel_dat),
        .mismatch_o (mismatch),
        .none_o     (none_ok)
    );

    always_comb begin
        s_d        = s_q;
        s_d.failed = failed_nx;
        s_d.xerr   = 1'b0;
        s_d.ovld   = '0;
        s_d.odat   = '0;

        if (s_q.mode == MODE_LOCK) begin
            s_d.fatal = s_q.fatal || none_ok;
            s_d.xerr  = mismatch && !s_d.fatal;
            if (sel_vld && !mismatch && !s_d.fatal) begin
                s_d.ovld[0]      = 1'b1;
                s_d.odat[DW-1:0] = sel_dat;
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (ch_vld[i] && usable[i] && !s_q.fatal) begin
                    s_d.ovld[i]          = 1'b1;
                    s_d.odat[i*DW +: DW] = ch_dat[i*DW +: DW];
                end
            end
        end

        if (mode_wr && sched_idle) begin
            s_d.mode = mode_e'(mode_sel);
            s_d.ovld = '0;
            s_d.odat = '0;
            s_d.xerr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_LOCK, failed: '0, fatal: 1'b0,
                     xerr: 1'b0, ovld: '0, odat: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign out_vld    = s_q.ovld;
    assign out_dat    = s_q.odat;
    assign lockstep_o = (s_q.mode == MODE_LOCK);
    assign ch_failed  = s_q.failed;
    assign fatal_o    = s_q.fatal;
    assign xchk_err   = s_q.xerr;
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mode_wr,
    input logic            sched_idle,
    input logic [1:0]      ch_err,
    input logic [1:0]      out_vld,
    input logic            lockstep_o,
    input logic [1:0]      ch_failed,
    input logic            fatal_o,
    input logic            xchk_err
);
    assert_port1_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lockstep_o |-> !out_vld[1]);

    assert_fatal_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |-> (out_vld == 2'b00));

    assert_fatal_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> fatal_o);

    assert_fail0_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ch_failed[0] |=> ch_failed[0]);

    assert_fail1_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ch_failed[1] |=> ch_failed[1]);

    assert_err_marks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_err != 2'b00) |=> ((ch_failed & $past(ch_err)) == $past(ch_err)));

    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_wr && sched_idle) |=> $stable(lockstep_o));

    assert_xchk_nocommit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xchk_err |-> (!out_vld[0] && lockstep_o));
endmodule

bind lsc_top lsc_checker #(.DW(DW)) u_lsc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .sched_idle (sched_idle),
    .ch_err     (ch_err),
    .out_vld    (out_vld),
    .lockstep_o (lockstep_o),
    .ch_failed  (ch_failed),
    .fatal_o    (fatal_o),
    .xchk_err   (xchk_err)
);

// File: tb/tb_lsc_top.sv
`timescale 1ns/1ps
module tb_lsc_top;
    localparam int DW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode_sel = 1'b1;
    logic            mode_wr = 1'b0;
    logic            sched_idle = 1'b0;
    logic [1:0]      ch_vld = '0;
    logic [2*DW-1:0] ch_dat = '0;
    logic [1:0]      ch_err = '0;
    logic [1:0]      out_vld;
    logic [2*DW-1:0] out_dat;
    logic            lockstep_o;
    logic [1:0]      ch_failed;
    logic            fatal_o;
    logic            xchk_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    lsc_top #(.DW(DW)) dut (
        .clk, .rst_n, .mode_sel, .mode_wr, .sched_idle, .ch_vld, .ch_dat,
        .ch_err, .out_vld, .out_dat, .lockstep_o, .ch_failed, .fatal_o,
        .xchk_err
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one input cycle, then stop just after the capturing edge
    task automatic cyc(input logic [1:0] v, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                       input logic [1:0] e, input logic wr, input logic sel, input logic idle);
        @(negedge clk);
        ch_vld = v; ch_dat = {d1, d0}; ch_err = e;
        mode_wr = wr; mode_sel = sel; sched_idle = idle;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ch_vld = '0; ch_err = '0; mode_wr = 1'b0; sched_idle = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        #2;
        // R1 reset state
        chk("R1 out_vld", out_vld, 0);
        chk("R1 lockstep", lockstep_o, 1);
        chk("R1 failed", ch_failed, 0);
        chk("R1 fatal", fatal_o, 0);
        chk("R1 xchk", xchk_err, 0);

        // R2 / R3: agreeing channels, every data value
        for (int a = 0; a < 16; a++) begin
            cyc(2'b11, DW'(a), DW'(a), 2'b00, 0, 1, 0);
            chk("R2 vld0", out_vld[0], 1);
            chk("R2 dat0", out_dat[DW-1:0], a);
            chk("R3 vld1", out_vld[1], 0);
        end

        // R6: data disagreement, all ordered differing pairs
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                if (a != b) begin
                    cyc(2'b11, DW'(a), DW'(b), 2'b00, 0, 1, 0);
                    chk("R6 xchk", xchk_err, 1);
                    chk("R6 nocommit", out_vld, 0);
                end
            end
        end
        cyc(2'b01, 4'h6, 4'h6, 2'b00, 0, 1, 0);
        chk("R6 valid differ", xchk_err, 1);
        cyc(2'b00, 4'h0, 4'h0, 2'b00, 0, 1, 0);
        chk("R6 pulse ends", xchk_err, 0);

        // R7: mode write outside an idle gap is ignored
        cyc(2'b11, 4'h2, 4'h2, 2'b00, 1, 0, 0);
        chk("R7 mode kept", lockstep_o, 1);
        chk("R7 out kept", out_vld, 2'b01);

        // R4 / R11: failover in the same cycle
        cyc(2'b11, 4'h3, 4'h5, 2'b01, 0, 1, 0);
        chk("R4 takes B", out_vld, 2'b01);
        chk("R4 B data", out_dat[DW-1:0], 5);
        chk("R4 A marked", ch_failed, 2'b01);
        cyc(2'b11, 4'h7, 4'h9, 2'b00, 0, 1, 0);
        chk("R4 follows B", out_dat[DW-1:0], 9);
        chk("R4 no xchk", xchk_err, 0);
        // R5: second channel lost
        cyc(2'b11, 4'h7, 4'h9, 2'b10, 0, 1, 0);
        chk("R5 fatal", fatal_o, 1);
        chk("R5 silent", out_vld, 0);
        cyc(2'b11, 4'h1, 4'h1, 2'b00, 0, 1, 0);
        chk("R5 fatal sticky", fatal_o, 1);
        chk("R5 still silent", out_vld, 0);

        // R8: accepted mode write clears pending output
        do_reset();
        cyc(2'b11, 4'h4, 4'h4, 2'b00, 1, 0, 1);
        chk("R8 parallel", lockstep_o, 0);
        chk("R8 cleared", out_vld, 0);

        // R9: independent channels, full cross product
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                logic v0, v1;
                v0 = ((a + b) % 3) != 0;
                v1 = ((a ^ b) & 1) == 0;
                cyc({v1, v0}, DW'(a), DW'(b), 2'b00, 0, 0, 0);
                chk("R9 vld", out_vld, {v1, v0});
                chk("R9 dat0", out_dat[DW-1:0], v0 ? a : 0);
                chk("R9 dat1", out_dat[2*DW-1:DW], v1 ? b : 0);
            end
        end

        // R10 / R11: error on channel 1 only silences port 1
        cyc(2'b11, 4'hA, 4'hB, 2'b10, 0, 0, 0);
        chk("R10 port1 silent", out_vld, 2'b01);
        chk("R10 port0 data", out_dat[DW-1:0], 4'hA);
        chk("R10 no fatal", fatal_o, 0);
        cyc(2'b11, 4'hC, 4'hD, 2'b00, 0, 0, 0);
        chk("R10 sticky", out_vld, 2'b01);
        chk("R10 failed", ch_failed, 2'b10);

        // back to lock-step with channel 1 failed: A forwarded, then loss
        cyc(2'b00, 4'h0, 4'h0, 2'b00, 1, 1, 1);
        chk("R8 to lockstep", lockstep_o, 1);
        cyc(2'b11, 4'hE, 4'h1, 2'b00, 0, 1, 0);
        chk("R2 A only", out_vld, 2'b01);
        chk("R2 A data", out_dat[DW-1:0], 4'hE);
        chk("R6 no xchk w/ failed", xchk_err, 0);
        cyc(2'b11, 4'hE, 4'hE, 2'b01, 0, 1, 0);
        chk("R5 fatal late", fatal_o, 1);
        chk("R11 nocommit", out_vld, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule